// File: doc/BRIEF.md
# Dual-Direction Rotate-Add Block Cipher Round Engine

This block runs a 64-bit block through a twelve-round rotate/add/xor cipher, either forward (encrypt) or backward (decrypt). It uses one shared datapath. The block is split into two 32-bit working words, A and B. A direction input, which may come straight from a board button, picks the direction. The engine latches it when a start strobe is accepted. Round subkeys are not stored here. The engine drives a subkey index, and the surrounding logic returns that subkey on a 32-bit input in the same cycle.

Each half-round takes two clock cycles, with a register between the two phases. When encrypting, phase one forms the xor of the two words and rotates it left. Phase two adds the subkey. When decrypting, phase one subtracts the subkey. Phase two rotates right and folds in the xor. No word is ever updated from a value that was derived from itself in the same cycle, so there is no combinational feedback loop. The deepest path is one 32-bit adder or a five-level barrel rotator plus an xor.

The controller is a four-state machine:
- **IDLE**: waits for start. When start arrives it loads the words, latches the direction, and moves to **WHITEN** (encrypt, index 0) or to **MIX1** (decrypt, index 25).
- **WHITEN**: applies a single add or subtract of the subkey. Encrypt steps 0→1→MIX1 at index 2. Decrypt steps 1→0→IDLE, which finishes the operation.
- **MIX1**: always moves to **MIX2**.
- **MIX2**:
  - Encrypt increments the index back to MIX1, or finishes at index 25.
  - Decrypt decrements the index back to MIX1, or goes to WHITEN at index 1 once index 2 is done.

Top module: `rc_round_core`

## Requirements
- R1: Word A is din[63:32] and word B is din[31:0]. The result is presented on dout with A in bits 63:32 and B in bits 31:0.
- R2: Encrypt (decrypt=0) computes the following, with S[k] being the subkey returned for index k:
  - whitening: A=A+S[0], then B=B+S[1];
  - then for i=1..12: A=rotl(A^B, B[4:0])+S[2i], then B=rotl(B^A, A[4:0])+S[2i+1].
- R3: Decrypt (decrypt=1) computes the following, so decrypting a ciphertext under the same subkeys returns the plaintext:
  - for i=12 down to 1: B=rotr(B-S[2i+1], A[4:0])^A, then A=rotr(A-S[2i], B[4:0])^B;
  - then B=B-S[1], then A=A-S[0].
- R4: Rotate amounts use only the low 5 bits of the other word (0 to 31 positions). Higher bits of that word have no effect on the amount, and an amount of 0 leaves the word unrotated.
- R5: done is a one-cycle pulse. It rises on the 50th rising edge after the edge that accepts start, which is the same edge that registers the final word.
- R6: After done, dout holds its value on every cycle until the next accepted start. Changes on din or decrypt while idle have no effect on it.
- R7: A start, din change or decrypt change arriving while an operation is in progress is ignored. The running operation completes with its original direction and data.
- R8: A synchronous reset (rst high at a rising edge) returns the engine to IDLE with done low and dout zero. It aborts any running operation, and a later start runs normally.
- R9: key_idx is always below 26. During encrypt it never decreases, from 0 in the first busy cycle to 25 in the last. During decrypt it never increases, from 25 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, accepted only while idle |
| decrypt | input | 1 | Direction: 0 encrypt, 1 decrypt; latched on accepted start |
| din | input | 64 | Input block, A in upper half, B in lower half |
| key_idx | output | 5 | Index of the subkey needed this cycle |
| key_in | input | 32 | Subkey for key_idx, valid in the same cycle |
| dout | output | 64 | Working words {A, B}; the result once done has pulsed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start arriving in the middle of a run, with the direction input flipped and a different block on din. The engine must keep the direction and data it latched and still produce the exact ciphertext or plaintext. The stimulus raises start, flips decrypt and inverts din at the tenth busy cycle, then compares the finished result with the bench model. Rotate amounts of 0 and 31, and words whose upper bits are set above a zero low field, are forced by directed blocks and all-zero or all-one subkeys. Random blocks with random subkeys are run forward against the model and then backward to the plaintext.

// File: rtl/rc_pkg.sv
package rc_pkg;

    // Controller states of the round engine.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WHITEN,
        ST_MIX1,
        ST_MIX2
    } rc_state_e;

endpackage

// File: rtl/rc_rotator.sv
// Barrel rotator built from log2(W) conditional stages.
module rc_rotator #(
    parameter int W    = 32,
    parameter bit LEFT = 1'b1,
    parameter int AW   = $clog2(W)
) (
    input  logic [W-1:0]  x,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  y
);

    logic [AW:0][W-1:0] stg;

    assign stg[0] = x;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [W-1:0] moved;
        if (LEFT) begin : g_left
            assign moved = {stg[s][W-1-SH:0], stg[s][W-1:W-SH]};
        end else begin : g_right
            assign moved = {stg[s][SH-1:0], stg[s][W-1:SH]};
        end
        assign stg[s+1] = amt[s] ? moved : stg[s];
    end

    assign y = stg[AW];

endmodule

// File: rtl/rc_addsub.sv
// Shared adder/subtractor; result always lands in a register upstream.
module rc_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);

    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end

endmodule

// File: rtl/rc_round_core.sv
// Two-phase-per-half-round cipher engine, both directions on one datapath.
module rc_round_core
    import rc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ROUNDS = 12,
    parameter int IDX_W  = $clog2(2 * ROUNDS + 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  decrypt,
    input  logic [2*WORD_W-1:0]   din,
    output logic [IDX_W-1:0]      key_idx,
    input  logic [WORD_W-1:0]     key_in,
    output logic [2*WORD_W-1:0]   dout,
    output logic                  done
);

    localparam int SHW = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_K  = IDX_W'(2 * ROUNDS + 1);
    localparam logic [IDX_W-1:0] FIRST_R = IDX_W'(2);
    localparam logic [IDX_W-1:0] ONE_K   = IDX_W'(1);

    rc_state_e         state_q, state_d;
    logic [IDX_W-1:0]  k_q, k_d;
    logic              mode_q;
    logic [WORD_W-1:0] a_q, b_q, t_q;
    logic              done_q;
    logic              fin;
    logic              idle_w;
    logic              ld_start;

    // Word selection: odd subkey index updates B, even updates A.
    logic [WORD_W-1:0] x_w, y_w;
    logic [WORD_W-1:0] as_a, as_y;
    logic [WORD_W-1:0] rotl_y, rotr_y;
    logic [WORD_W-1:0] t_d, wr_val;
    logic              wr_en;

    assign idle_w   = (state_q == ST_IDLE);
    assign ld_start = idle_w && start;
    assign x_w      = k_q[0] ? b_q : a_q;
    assign y_w      = k_q[0] ? a_q : b_q;

    // Operand of the adder: the rotated word held in t_q during the
    // encrypt add phase, otherwise the target word itself.
    assign as_a = (state_q == ST_MIX2) ? t_q : x_w;

    rc_addsub #(.W(WORD_W)) u_addsub (
        .a   (as_a),
        .b   (key_in),
        .sub (mode_q),
        .y   (as_y)
    );

    rc_rotator #(.W(WORD_W), .LEFT(1'b1)) u_rotl (
        .x   (x_w ^ y_w),
        .amt (y_w[SHW-1:0]),
        .y   (rotl_y)
    );

    rc_rotator #(.W(WORD_W), .LEFT(1'b0)) u_rotr (
        .x   (t_q),
        .amt (y_w[SHW-1:0]),
        .y   (rotr_y)
    );

    // Phase-one result and word write-back value.
    assign t_d    = mode_q ? as_y : rotl_y;
    assign wr_en  = (state_q == ST_WHITEN) || (state_q == ST_MIX2);
    assign wr_val = (state_q == ST_MIX2 && mode_q) ? (rotr_y ^ y_w) : as_y;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
        end else begin
            state_q <= state_d;
            k_q     <= k_d;
        end
    end

    // Next state and subkey index.
    always_comb begin
        state_d = state_q;
        k_d     = k_q;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (decrypt) begin
                        state_d = ST_MIX1;
                        k_d     = LAST_K;
                    end else begin
                        state_d = ST_WHITEN;
                        k_d     = '0;
                    end
                end
            end
            ST_WHITEN: begin
                if (!mode_q) begin
                    if (k_q == '0) begin
                        k_d = ONE_K;
                    end else begin
                        state_d = ST_MIX1;
                        k_d     = FIRST_R;
                    end
                end else begin
                    if (k_q == ONE_K) begin
                        k_d = '0;
                    end else begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end
                end
            end
            ST_MIX1: begin
                state_d = ST_MIX2;
            end
            ST_MIX2: begin
                if (!mode_q) begin
                    if (k_q == LAST_K) begin
                        state_d = ST_IDLE;
                        fin     = 1'b1;
                    end else begin
                        state_d = ST_MIX1;
                        k_d     = k_q + ONE_K;
                    end
                end else begin
                    if (k_q == FIRST_R) begin
                        state_d = ST_WHITEN;
                        k_d     = ONE_K;
                    end else begin
                        state_d = ST_MIX1;
                        k_d     = k_q - ONE_K;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Datapath registers and outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            t_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (ld_start) begin
                a_q    <= din[2*WORD_W-1:WORD_W];
                b_q    <= din[WORD_W-1:0];
                mode_q <= decrypt;
            end
            if (state_q == ST_MIX1) begin
                t_q <= t_d;
            end
            if (wr_en) begin
                if (k_q[0]) b_q <= wr_val;
                else        a_q <= wr_val;
            end
        end
    end

    assign key_idx = k_q;
    assign dout    = {a_q, b_q};
    assign done    = done_q;

endmodule

// File: rtl/rc_round_core_chk.sv
// Property checker attached to the round engine.
module rc_round_core_chk #(
    parameter int IDX_W  = 5,
    parameter int NKEY   = 26,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic [DATA_W-1:0] dout,
    input logic [IDX_W-1:0]  key_idx,
    input logic              idle_w,
    input logic              mode_q
);

    // R5: completion is a single-cycle pulse.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: done only follows a busy cycle.
    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(idle_w));

    // R6: result holds while idle with no start.
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (idle_w && !start) |=> $stable(dout));

    // R7: direction cannot change mid-operation.
    p_mode_latched_r7: assert property (@(posedge clk) disable iff (rst)
        !idle_w |=> $stable(mode_q));

    // R9: subkey index stays within the schedule.
    p_key_range_r9: assert property (@(posedge clk) disable iff (rst)
        int'(key_idx) < NKEY);

endmodule

bind rc_round_core rc_round_core_chk #(
    .IDX_W  (IDX_W),
    .NKEY   (2 * ROUNDS + 2),
    .DATA_W (2 * WORD_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .dout    (dout),
    .key_idx (key_idx),
    .idle_w  (idle_w),
    .mode_q  (mode_q)
);

// File: tb/rc_round_core_bench.sv
module rc_round_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS     = 12;
    localparam int NKEY       = 2 * ROUNDS + 2;
    localparam int LAT        = 2 + 4 * ROUNDS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [63:0] din = '0;
    logic [4:0]  key_idx;
    logic [31:0] key_in;
    logic [63:0] dout;
    logic        done;

    logic [31:0] keys [0:NKEY-1];

    int checks = 0;
    int errors = 0;

    assign key_in = (int'(key_idx) < NKEY) ? keys[key_idx] : 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_round_core u_rc_round_core (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .decrypt (decrypt),
        .din     (din),
        .key_idx (key_idx),
        .key_in  (key_in),
        .dout    (dout),
        .done    (done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rol32(input logic [31:0] x, input logic [4:0] n);
        logic [63:0] d;
        d = {x, x} << n;
        return d[63:32];
    endfunction

    function automatic logic [31:0] ror32(input logic [31:0] x, input logic [4:0] n);
        logic [63:0] d;
        d = {x, x} >> n;
        return d[31:0];
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] p);
        logic [31:0] a, b;
        a = p[63:32] + keys[0];
        b = p[31:0] + keys[1];
        for (int i = 1; i <= ROUNDS; i++) begin
            a = rol32(a ^ b, b[4:0]) + keys[2*i];
            b = rol32(b ^ a, a[4:0]) + keys[2*i+1];
        end
        return {a, b};
    endfunction

    function automatic logic [63:0] ref_dec(input logic [63:0] c);
        logic [31:0] a, b;
        a = c[63:32];
        b = c[31:0];
        for (int i = ROUNDS; i >= 1; i--) begin
            b = ror32(b - keys[2*i+1], a[4:0]) ^ a;
            a = ror32(a - keys[2*i], b[4:0]) ^ b;
        end
        b = b - keys[1];
        a = a - keys[0];
        return {a, b};
    endfunction

    // One operation; checks latency (R5), pulse width (R5) and index order (R9).
    task automatic run(input bit m, input logic [63:0] data, input bit poke, output logic [63:0] res);
        int n;
        bit key_ok;
        logic [4:0] first, prev;
        @(negedge clk);
        start = 1'b1; decrypt = m; din = data;
        @(negedge clk);
        start = 1'b0;
        n = 1; key_ok = 1'b1; first = key_idx; prev = key_idx;
        while (!done && n < LAT + 20) begin
            if (m ? (key_idx > prev) : (key_idx < prev)) key_ok = 1'b0;
            prev = key_idx;
            if (poke && n == 10) begin start = 1'b1; decrypt = ~m; din = ~data; end
            if (poke && n == 11) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n == LAT + 1, "R5 latency", 64'(n), 64'(LAT + 1));
        chk(key_ok, "R9 monotonic index", 64'(key_ok), 64'd1);
        chk(first == (m ? 5'd25 : 5'd0), "R9 first index", 64'(first), m ? 64'd25 : 64'd0);
        chk(prev == (m ? 5'd0 : 5'd25), "R9 last index", 64'(prev), m ? 64'd0 : 64'd25);
        res = dout;
        @(negedge clk);
        chk(!done, "R5 pulse width", 64'(done), 64'd0);
    endtask

    task automatic set_keys_random();
        for (int k = 0; k < NKEY; k++) keys[k] = $urandom();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] c, p, r, held;
        logic [63:0] dir_vec [0:5];
        void'($urandom(32'd4242));
        set_keys_random();

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(dout == 64'h0, "R8 reset dout", dout, 64'h0);
        chk(!done, "R8 reset done", 64'(done), 64'd0);
        rst = 1'b0;

        // R1 R4: directed blocks forcing amounts 0, 31 and high bits above a zero field
        dir_vec[0] = 64'h0;
        dir_vec[1] = 64'h0000_001F_0000_001F;
        dir_vec[2] = 64'hFFFF_FFE0_FFFF_FFE0;
        dir_vec[3] = 64'h1234_5678_0000_0000;
        dir_vec[4] = 64'h8000_0000_FFFF_FFFF;
        dir_vec[5] = 64'hDEAD_BEEF_0000_0020;
        for (int j = 0; j < 6; j++) begin
            for (int k = 0; k < NKEY; k++) keys[k] = (j % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF;
            run(1'b0, dir_vec[j], 1'b0, c);
            chk(c == ref_enc(dir_vec[j]), "R1 R4 directed encrypt", c, ref_enc(dir_vec[j]));
            run(1'b1, c, 1'b0, p);
            chk(p == dir_vec[j], "R3 R4 directed round trip", p, dir_vec[j]);
        end

        // R2 R3: random blocks with random subkeys
        for (int j = 0; j < 10; j++) begin
            set_keys_random();
            p = {$urandom(), $urandom()};
            run(1'b0, p, 1'b0, c);
            chk(c == ref_enc(p), "R2 encrypt vs model", c, ref_enc(p));
            run(1'b1, c, 1'b0, r);
            chk(r == p, "R3 decrypt round trip", r, p);
            chk(r == ref_dec(c), "R3 decrypt vs model", r, ref_dec(c));
        end

        // R6: result holds while idle inputs move
        held = dout;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            din = {$urandom(), $urandom()};
            decrypt = ~decrypt;
            chk(dout == held, "R6 hold after done", dout, held);
        end

        // R7: start, direction and data changes mid-run are ignored
        set_keys_random();
        p = 64'h0123_4567_89AB_CDEF;
        run(1'b0, p, 1'b1, c);
        chk(c == ref_enc(p), "R7 ignored start during encrypt", c, ref_enc(p));
        run(1'b1, c, 1'b1, r);
        chk(r == p, "R7 ignored start during decrypt", r, p);

        // R8: reset in the middle of an operation
        @(negedge clk);
        start = 1'b1; decrypt = 1'b0; din = 64'hCAFE_F00D_5555_AAAA;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(dout == 64'h0, "R8 abort dout", dout, 64'h0);
        chk(!done, "R8 abort done", 64'(done), 64'd0);
        for (int j = 0; j < LAT + 4; j++) begin
            @(negedge clk);
            if (done) chk(1'b0, "R8 stale done after abort", 64'd1, 64'd0);
        end
        p = 64'hCAFE_F00D_5555_AAAA;
        run(1'b0, p, 1'b0, c);
        chk(c == ref_enc(p), "R8 run after abort", c, ref_enc(p));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule